// File: doc/BRIEF.md
# Complementary Output Dead-Time Inserter

This block sits between the pulse-width generator of a timer and the output drivers of a half bridge. For every timer channel it takes one raw waveform and drives a pair of outputs: a true output that follows the raw level and a complementary output that follows its inverse. The two outputs of a pair are never high together. Before either output of a pair rises, both are held low for a programmable number of clock cycles, so the switch being turned off has time to stop conducting before the other one turns on.

One 8-bit dead-time setting serves every channel. It holds two 4-bit delays: one applies to rising edges of the true output and the other to rising edges of the complementary output. Falling edges take effect with no delay. Each channel samples the setting when it sees an edge and counts that delay down on its own counter. A later change to the setting therefore affects only the next edge. A count that is already running finishes with the value it loaded.

Top module: `dt_inserter`

## Requirements
- R1: On every channel, `out_true` and `out_comp` are never both 1 in the same cycle.
- R2: The dead-time register is 8 bits wide. When `cfg_we` is 1 at a clock edge, `cfg_wdata` is stored, and `cfg_rdata` shows the stored value from the next cycle on.
- R3: While reset is held, and on the first cycle after it, the register reads 0x00, every `out_true` is 0 and every `out_comp` is 1.
- R4: Bits 7:4 of the register hold the true-output delay D. When the clock edge at cycle k first samples a channel's raw input as 1, that channel's `out_comp` is 0 after edge k. For D > 0, `out_true` stays 0 through edge k+D-1 and is 1 after edge k+D.
- R5: Bits 3:0 of the register hold the complementary-output delay D. When the clock edge at cycle k first samples a channel's raw input as 0, `out_true` is 0 after edge k. For D > 0, `out_comp` stays 0 through edge k+D-1 and is 1 after edge k+D.
- R6: A delay field of 0 makes the pending output rise after the same edge k that sampled the raw edge. The other output still falls after that edge.
- R7: After any edge that samples the raw input as 0, `out_true` is 0. After any edge that samples it as 1, `out_comp` is 0.
- R8: If the raw input changes again before a delay count finishes, the count restarts from the delay of the new edge. The output that was pending never rises.
- R9: Every channel uses the same register and keeps its own independent count.
- R10: The delay in effect for an edge is the register value at the clock edge that samples it. A write during a running count does not change when that count ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the dead-time register |
| cfg_wdata | input | 8 | Write data: [7:4] true-output delay, [3:0] complementary-output delay |
| cfg_rdata | output | 8 | Current register contents |
| pwm_raw | input | CHANNELS | Raw waveform, one bit per channel |
| out_true | output | CHANNELS | True output of each pair |
| out_comp | output | CHANNELS | Complementary output of each pair |

## Verification
The properties assume that each raw input is a clean synchronous level that is stable around the sampling edge. They also assume that the value sampled on the cycle before a checked edge really reflects the previous raw level. That second assumption can fail only on the first cycle after reset, and there the relevant checks simply do not trigger. The bench changes raw inputs and the write strobe only on the falling clock edge. Before each scenario it brings every channel back to a settled low state, so each edge it applies starts from a known level with no count running.

// File: rtl/dt_pkg.sv
package dt_pkg;

    // Width of one delay field and of the whole setting register
    localparam int DT_NIB_W = 4;
    localparam int DT_REG_W = 2 * DT_NIB_W;

    typedef logic [DT_NIB_W-1:0] nib_t;

    localparam nib_t NIB_ZERO = '0;
    localparam nib_t NIB_ONE  = nib_t'(1);

    // Upper field delays the true output, lower field the complementary output
    typedef struct packed {
        nib_t rise_true;
        nib_t rise_comp;
    } dt_fields_t;

    // Per-channel state: last sampled raw level, remaining count, outputs
    typedef struct packed {
        logic level;
        nib_t cnt;
        logic out_t;
        logic out_c;
    } ch_state_t;

    localparam ch_state_t CH_RESET = '{
        level: 1'b0,
        cnt:   NIB_ZERO,
        out_t: 1'b0,
        out_c: 1'b1
    };

    // Delay that applies to the output rising because of a raw edge
    function automatic nib_t edge_delay(input dt_fields_t f, input logic new_level);
        return new_level ? f.rise_true : f.rise_comp;
    endfunction

endpackage

// File: rtl/dt_cfg_reg.sv
module dt_cfg_reg
    import dt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [DT_REG_W-1:0] wdata,
    output dt_fields_t          fields
);

    dt_fields_t fields_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= '0;
        end else if (we) begin
            fields_q <= dt_fields_t'(wdata);
        end
    end

    assign fields = fields_q;

endmodule

// File: rtl/dt_channel.sv
module dt_channel
    import dt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       raw,
    input  dt_fields_t dt,
    output logic       out_t,
    output logic       out_c
);

    ch_state_t st_q;
    ch_state_t st_d;
    logic      edge_seen;
    nib_t      load_val;

    always_comb begin
        st_d      = st_q;
        edge_seen = (raw != st_q.level);
        load_val  = edge_delay(dt, raw);

        if (edge_seen) begin
            // New edge: the falling output drops now, the other waits
            st_d.level = raw;
            st_d.cnt   = load_val;
            if (raw) begin
                st_d.out_c = 1'b0;
                st_d.out_t = (load_val == NIB_ZERO);
            end else begin
                st_d.out_t = 1'b0;
                st_d.out_c = (load_val == NIB_ZERO);
            end
        end else if (st_q.cnt != NIB_ZERO) begin
            st_d.cnt = st_q.cnt - NIB_ONE;
            if (st_q.cnt == NIB_ONE) begin
                if (st_q.level) begin
                    st_d.out_t = 1'b1;
                end else begin
                    st_d.out_c = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= CH_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_t = st_q.out_t;
    assign out_c = st_q.out_c;

endmodule

// File: rtl/dt_inserter.sv
module dt_inserter
    import dt_pkg::*;
#(
    parameter int CHANNELS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [DT_REG_W-1:0] cfg_wdata,
    output logic [DT_REG_W-1:0] cfg_rdata,
    input  logic [CHANNELS-1:0] pwm_raw,
    output logic [CHANNELS-1:0] out_true,
    output logic [CHANNELS-1:0] out_comp
);

    dt_fields_t shared_dt;

    dt_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .fields (shared_dt)
    );

    assign cfg_rdata = shared_dt;

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        dt_channel u_chan (
            .clk   (clk),
            .rst   (rst),
            .raw   (pwm_raw[ch]),
            .dt    (shared_dt),
            .out_t (out_true[ch]),
            .out_c (out_comp[ch])
        );
    end

endmodule

// File: rtl/dt_inserter_chk.sv
module dt_inserter_chk
    import dt_pkg::*;
#(
    parameter int CHANNELS = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_we,
    input logic [DT_REG_W-1:0] cfg_wdata,
    input logic [DT_REG_W-1:0] cfg_rdata,
    input logic [CHANNELS-1:0] pwm_raw,
    input logic [CHANNELS-1:0] out_true,
    input logic [CHANNELS-1:0] out_comp
);

    p_no_overlap_r1: assert property (@(posedge clk) disable iff (rst)
        (out_true & out_comp) == '0);

    p_reg_write_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata == $past(cfg_wdata));

    p_reset_state_r3: assert property (@(posedge clk)
        rst |=> (out_true == '0) && (out_comp == '1) && (cfg_rdata == '0));

    for (genvar i = 0; i < CHANNELS; i++) begin : g_chk
        p_true_low_on_low_r7: assert property (@(posedge clk) disable iff (rst)
            !pwm_raw[i] |=> !out_true[i]);

        p_comp_low_on_high_r7: assert property (@(posedge clk) disable iff (rst)
            pwm_raw[i] |=> !out_comp[i]);

        p_true_waits_r4: assert property (@(posedge clk) disable iff (rst)
            (!$past(pwm_raw[i]) && pwm_raw[i] && cfg_rdata[DT_REG_W-1 -: DT_NIB_W] != '0)
            |=> !out_true[i]);

        p_comp_waits_r5: assert property (@(posedge clk) disable iff (rst)
            ($past(pwm_raw[i]) && !pwm_raw[i] && cfg_rdata[DT_NIB_W-1:0] != '0)
            |=> !out_comp[i]);

        p_true_zero_delay_r6: assert property (@(posedge clk) disable iff (rst)
            (!$past(pwm_raw[i]) && pwm_raw[i] && cfg_rdata[DT_REG_W-1 -: DT_NIB_W] == '0)
            |=> out_true[i]);

        p_comp_zero_delay_r6: assert property (@(posedge clk) disable iff (rst)
            ($past(pwm_raw[i]) && !pwm_raw[i] && cfg_rdata[DT_NIB_W-1:0] == '0)
            |=> out_comp[i]);
    end

endmodule

bind dt_inserter dt_inserter_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pwm_raw   (pwm_raw),
    .out_true  (out_true),
    .out_comp  (out_comp)
);

// File: tb/dt_inserter_bench.sv
`timescale 1ns/1ps
module dt_inserter_bench;

    localparam int CH = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic [CH-1:0] pwm_raw = '0;
    logic [CH-1:0] out_true;
    logic [CH-1:0] out_comp;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dt_inserter #(.CHANNELS(CH)) u_dt_inserter (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pwm_raw   (pwm_raw),
        .out_true  (out_true),
        .out_comp  (out_comp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Bring every channel to raw low with no count running
    task automatic settle();
        @(negedge clk);
        pwm_raw = '0;
        write_reg(8'h00);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R3 true after reset", 32'(out_true), 32'(0));
        check("R3 comp after reset", 32'(out_comp), 32'((1 << CH) - 1));
        check("R3 register after reset", 32'(cfg_rdata), 32'h00);
    endtask

    task automatic t_reg_rw();
        write_reg(8'hA5);
        check("R2 readback A5", 32'(cfg_rdata), 32'hA5);
        write_reg(8'h3C);
        check("R2 readback 3C", 32'(cfg_rdata), 32'h3C);
        settle();
    endtask

    // Rise then fall on one channel with the given delays
    task automatic t_edge(input int ch, input int hi, input int lo, input string req);
        settle();
        write_reg(8'((hi << 4) | lo));
        pwm_raw[ch] = 1'b1;
        for (int j = 0; j <= hi + 1; j++) begin
            @(negedge clk);
            check({req, " R4 true rise"}, 32'(out_true[ch]), 32'(j >= hi));
            check({req, " R7 comp low"}, 32'(out_comp[ch]), 32'(0));
            check("R1 no overlap", 32'(out_true & out_comp), 32'(0));
        end
        pwm_raw[ch] = 1'b0;
        for (int j = 0; j <= lo + 1; j++) begin
            @(negedge clk);
            check({req, " R5 comp rise"}, 32'(out_comp[ch]), 32'(j >= lo));
            check({req, " R7 true low"}, 32'(out_true[ch]), 32'(0));
            check("R1 no overlap", 32'(out_true & out_comp), 32'(0));
        end
    endtask

    task automatic t_retoggle();
        settle();
        write_reg(8'h53);
        pwm_raw[1] = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check("R8 true pending", 32'(out_true[1]), 32'(0));
        end
        pwm_raw[1] = 1'b0;
        for (int j = 0; j <= 7; j++) begin
            @(negedge clk);
            check("R8 abandoned true never rises", 32'(out_true[1]), 32'(0));
            check("R8 comp restarts", 32'(out_comp[1]), 32'(j >= 3));
        end
        pwm_raw[1] = 1'b1;
        @(negedge clk);
        pwm_raw[1] = 1'b0;
        for (int j = 0; j <= 7; j++) begin
            @(negedge clk);
            check("R8 true stays low after short pulse", 32'(out_true[1]), 32'(0));
            check("R8 comp restarts after short pulse", 32'(out_comp[1]), 32'(j >= 3));
        end
    endtask

    task automatic t_midchange();
        settle();
        write_reg(8'h62);
        pwm_raw[2] = 1'b1;
        for (int j = 0; j <= 7; j++) begin
            @(negedge clk);
            if (j == 1) begin
                cfg_we    = 1'b1;
                cfg_wdata = 8'h14;
            end else begin
                cfg_we    = 1'b0;
            end
            check("R10 running count keeps old delay", 32'(out_true[2]), 32'(j >= 6));
        end
        pwm_raw[2] = 1'b0;
        for (int j = 0; j <= 5; j++) begin
            @(negedge clk);
            check("R10 next edge uses new lower field", 32'(out_comp[2]), 32'(j >= 4));
        end
        pwm_raw[2] = 1'b1;
        for (int j = 0; j <= 2; j++) begin
            @(negedge clk);
            check("R10 next edge uses new upper field", 32'(out_true[2]), 32'(j >= 1));
        end
    endtask

    task automatic t_shared();
        settle();
        write_reg(8'h23);
        pwm_raw = '1;
        for (int j = 0; j <= 3; j++) begin
            @(negedge clk);
            check("R9 all true", 32'(out_true), (j >= 2) ? 32'((1 << CH) - 1) : 32'(0));
            check("R9 all comp low", 32'(out_comp), 32'(0));
        end
        pwm_raw[0] = 1'b0;
        for (int j = 0; j <= 4; j++) begin
            @(negedge clk);
            check("R9 channel 0 comp", 32'(out_comp[0]), 32'(j >= 3));
            check("R9 other channels hold", 32'(out_true[CH-1:1]), 32'((1 << (CH - 1)) - 1));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reg_rw();
        t_edge(0, 3, 2, "ch0 d3/2");
        t_edge(1, 0, 0, "R6 zero");
        t_edge(2, 15, 1, "ch2 d15/1");
        t_edge(0, 0, 7, "R6 zero true");
        t_retoggle();
        t_midchange();
        t_shared();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog expired actual=1 expected=0");
        report();
    end

endmodule